// File: doc/BRIEF.md
# Two-Group Barrel Thread Picker

This block is the thread-select stage of a fine-grained multithreaded in-order core. It tracks eight hardware threads in two fixed groups of four. Threads 0 to 3 form the low group and threads 4 to 7 form the high group. Each group drives its own integer ALU. On every cycle the block chooses at most one eligible thread per group, so up to two threads issue together.

Eligibility combines the thread's ready flag with three hazard rules:

- A multiply stalls only the thread that issued it. Other threads can keep multiplies flowing through the pipelined multiplier.
- A single shared divider accepts one divide at a time. It stays busy until the datapath returns a completion pulse.
- A floating-point op marked as dependent must wait a fixed distance behind its own thread's previous floating-point issue.

Within a group, the choice rotates in round-robin order among the eligible threads.

Top module: `barrel_thread_picker`

## Requirements
- R1: Grants go only to threads 0-3 on `grant_lo` (bit i = thread i) and threads 4-7 on `grant_hi` (bit i = thread 4+i). Each vector has at most one bit set, and each valid output is high exactly when its vector is non-zero.
- R2: A thread is granted only if its `thr_ready` bit is high and no hazard blocks it. When no thread of a group is eligible, that group's vector is all zeros and its valid is low.
- R3: Each group has a priority pointer. The search starts at the pointed thread and wraps within the group. After a grant to local index i, the pointer becomes (i+1) mod 4. Without a grant, the pointer is unchanged.
- R4: `thr_op[2t+1:2t]` gives thread t's op class: 0 integer ALU, 1 multiply, 2 divide, 3 floating point. `thr_fp_dep[t]` marks a floating-point op that depends on an earlier floating-point result.
- R5: A thread granted a multiply in cycle c gets no grant in cycles c+1 through c+MUL_LAT-1 (default MUL_LAT = 5). It is eligible again from c+MUL_LAT. Multiplies of other threads are not delayed.
- R6: A granted divide marks the divider busy from the next cycle until the cycle after a `div_done` pulse. While the divider is busy, no thread is granted a divide and the owning thread is granted nothing. Non-divide ops of other threads still issue.
- R7: If the low group grants a divide, no high-group thread is granted a divide in the same cycle. The high group picks among its remaining eligible threads.
- R8: A dependent floating-point op of thread t is not granted until FP_LAT cycles (default 6) after thread t's last floating-point grant. Non-dependent floating-point ops are not delayed.
- R9: A `div_done` pulse while the divider is idle has no effect. A divide issued afterwards still holds the divider busy.
- R10: Synchronous active-high `rst` clears all multiply, divide and floating-point blocking state and points both groups at their first thread (thread 0 and thread 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | 8 | Per-thread ready flag |
| thr_op | input | 16 | Per-thread op class, two bits per thread |
| thr_fp_dep | input | 8 | Per-thread flag: floating-point op depends on a prior FP result |
| div_done | input | 1 | Completion pulse from the divider |
| grant_lo | output | 4 | One-hot grant for threads 0-3 |
| valid_lo | output | 1 | Low-group grant present |
| grant_hi | output | 4 | One-hot grant for threads 4-7 |
| valid_hi | output | 1 | High-group grant present |

## Verification
The assertions check the following on every cycle:

- Per-group one-hotness of the grants.
- That grants go only to ready threads.
- The ban on two concurrent divides.
- The ban on a thread issuing in the cycle right after its own multiply or right after a floating-point op on which its dependent op waits.

Only the bench's scenarios can show the rest:

- The full multiply and floating-point stall windows.
- The round-robin rotation order.
- Release of the divider on `div_done`.
- That an idle `div_done` leaves a later divide protected.

The bench shows these by comparing every cycle against a reference model under directed and random traffic.

// File: rtl/barrel_thread_picker.sv
module barrel_thread_picker #(
  parameter int MUL_LAT = 5,
  parameter int FP_LAT  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  thr_ready,
  input  logic [15:0] thr_op,
  input  logic [7:0]  thr_fp_dep,
  input  logic        div_done,
  output logic [3:0]  grant_lo,
  output logic        valid_lo,
  output logic [3:0]  grant_hi,
  output logic        valid_hi
);
  localparam int MAXLAT = (MUL_LAT > FP_LAT) ? MUL_LAT : FP_LAT;
  localparam int CW = $clog2(MAXLAT + 1);
  localparam logic [CW-1:0] MUL_LOAD = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] FP_LOAD  = CW'(FP_LAT - 1);
  localparam logic [1:0] OP_MUL = 2'd1, OP_DIV = 2'd2, OP_FP = 2'd3;

  logic [CW-1:0] mul_cnt [8];
  logic [CW-1:0] fp_cnt  [8];
  logic          div_busy;
  logic [2:0]    div_owner;
  logic [1:0]    ptr_lo, ptr_hi;
  logic [7:0]    is_mul, is_div, is_fp, elig, grant_all;
  logic [3:0]    elig_hi;
  logic          lo_div, div_issue;
  logic [2:0]    div_pick;

  function automatic logic [3:0] rr_pick(input logic [3:0] req, input logic [1:0] ptr);
    logic [1:0] idx;
    rr_pick = '0;
    for (int k = 3; k >= 0; k--) begin
      idx = ptr + 2'(k);
      if (req[idx]) rr_pick = 4'b0001 << idx;
    end
  endfunction

  function automatic logic [1:0] enc4(input logic [3:0] oh);
    enc4 = {oh[3] | oh[2], oh[3] | oh[1]};
  endfunction

  always_comb begin
    for (int t = 0; t < 8; t++) begin
      is_mul[t] = thr_op[2*t +: 2] == OP_MUL;
      is_div[t] = thr_op[2*t +: 2] == OP_DIV;
      is_fp[t]  = thr_op[2*t +: 2] == OP_FP;
      elig[t]   = thr_ready[t] && (mul_cnt[t] == '0)
                  && !(div_busy && div_owner == 3'(t))
                  && !(is_div[t] && div_busy)
                  && !(is_fp[t] && thr_fp_dep[t] && fp_cnt[t] != '0);
    end
  end

  assign grant_lo  = rr_pick(elig[3:0], ptr_lo);
  assign lo_div    = |(grant_lo & is_div[3:0]);
  assign elig_hi   = elig[7:4] & ~(is_div[7:4] & {4{lo_div}});
  assign grant_hi  = rr_pick(elig_hi, ptr_hi);
  assign valid_lo  = |grant_lo;
  assign valid_hi  = |grant_hi;
  assign grant_all = {grant_hi, grant_lo};
  assign div_issue = |(grant_all & is_div);
  assign div_pick  = lo_div ? {1'b0, enc4(grant_lo)} : {1'b1, enc4(grant_hi)};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_lo    <= '0;
      ptr_hi    <= '0;
      div_busy  <= 1'b0;
      div_owner <= '0;
      for (int t = 0; t < 8; t++) begin
        mul_cnt[t] <= '0;
        fp_cnt[t]  <= '0;
      end
    end else begin
      if (valid_lo) ptr_lo <= enc4(grant_lo) + 2'd1;
      if (valid_hi) ptr_hi <= enc4(grant_hi) + 2'd1;
      if (div_issue) begin
        div_busy  <= 1'b1;
        div_owner <= div_pick;
      end else if (div_done) begin
        div_busy <= 1'b0;
      end
      for (int t = 0; t < 8; t++) begin
        if (grant_all[t] && is_mul[t]) mul_cnt[t] <= MUL_LOAD;
        else if (mul_cnt[t] != '0)     mul_cnt[t] <= mul_cnt[t] - 1'b1;
        if (grant_all[t] && is_fp[t])  fp_cnt[t]  <= FP_LOAD;
        else if (fp_cnt[t] != '0)      fp_cnt[t]  <= fp_cnt[t] - 1'b1;
      end
    end
  end

  AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_lo) && $onehot0(grant_hi)); // R1
  AST_READY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (grant_all & ~thr_ready) == 8'd0); // R2
  AST_DIV_GROUP_ORDER: assert property (@(posedge clk) disable iff (rst)
    !(lo_div && |(grant_hi & is_div[7:4]))); // R7
  AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(div_issue)) |-> !div_issue); // R6

  generate
    if (MUL_LAT > 1) begin : g_mul_chk
      AST_MUL_SAME_THREAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && |$past(grant_all & is_mul)) |-> (($past(grant_all & is_mul) & grant_all) == 8'd0)); // R5
    end
    if (FP_LAT > 1) begin : g_fp_chk
      AST_FP_DEP_GAP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(grant_all & is_fp) & grant_all & is_fp & thr_fp_dep) == 8'd0)); // R8
    end
  endgenerate
endmodule

// File: tb/test_barrel_thread_picker.sv
`timescale 1ns/1ps
module test_barrel_thread_picker;
  localparam int MUL_LAT = 5;
  localparam int FP_LAT  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  thr_ready = '0;
  logic [15:0] thr_op = '0;
  logic [7:0]  thr_fp_dep = '0;
  logic        div_done = 1'b0;
  logic [3:0]  grant_lo, grant_hi;
  logic        valid_lo, valid_hi;

  int checks = 0;
  int errors = 0;

  int m_mul [8];
  int m_fp  [8];
  bit m_busy;
  int m_owner, m_plo, m_phi;

  always #10 clk = ~clk;

  barrel_thread_picker #(.MUL_LAT(MUL_LAT), .FP_LAT(FP_LAT)) i_barrel_thread_picker (
    .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_op(thr_op),
    .thr_fp_dep(thr_fp_dep), .div_done(div_done),
    .grant_lo(grant_lo), .valid_lo(valid_lo), .grant_hi(grant_hi), .valid_hi(valid_hi));

  function automatic logic [1:0] opc(int t);
    return thr_op[2*t +: 2];
  endfunction

  function automatic logic [3:0] first_from(logic [3:0] req, int p);
    for (int k = 0; k < 4; k++) begin
      if (req[(p + k) % 4]) return 4'(1 << ((p + k) % 4));
    end
    return 4'd0;
  endfunction

  function automatic int idx_of(logic [3:0] oh);
    for (int i = 0; i < 4; i++) if (oh[i]) return i;
    return 0;
  endfunction

  task automatic model_pick(output logic [3:0] elo, output logic [3:0] ehi);
    logic [7:0] el;
    bit lodiv;
    for (int t = 0; t < 8; t++)
      el[t] = thr_ready[t] && m_mul[t] == 0 && !(m_busy && m_owner == t)
              && !(opc(t) == 2'd2 && m_busy)
              && !(opc(t) == 2'd3 && thr_fp_dep[t] && m_fp[t] > 0);
    elo = first_from(el[3:0], m_plo);
    lodiv = (elo != 0) && opc(idx_of(elo)) == 2'd2;
    if (lodiv) for (int i = 0; i < 4; i++) if (opc(4 + i) == 2'd2) el[4 + i] = 1'b0;
    ehi = first_from(el[7:4], m_phi);
  endtask

  task automatic model_advance(logic [3:0] elo, logic [3:0] ehi);
    logic [7:0] g;
    bit issued_div;
    g = {ehi, elo};
    issued_div = 1'b0;
    for (int t = 0; t < 8; t++) begin
      if (g[t] && opc(t) == 2'd1) m_mul[t] = MUL_LAT - 1;
      else if (m_mul[t] > 0) m_mul[t]--;
      if (g[t] && opc(t) == 2'd3) m_fp[t] = FP_LAT - 1;
      else if (m_fp[t] > 0) m_fp[t]--;
      if (g[t] && opc(t) == 2'd2) begin
        issued_div = 1'b1;
        m_owner = t;
      end
    end
    if (issued_div) m_busy = 1'b1;
    else if (div_done) m_busy = 1'b0;
    if (elo != 0) m_plo = (idx_of(elo) + 1) % 4;
    if (ehi != 0) m_phi = (idx_of(ehi) + 1) % 4;
  endtask

  task automatic step(string tag);
    logic [3:0] elo, ehi;
    @(negedge clk);
    #1;
    model_pick(elo, ehi);
    checks++;
    if (grant_lo !== elo || grant_hi !== ehi || valid_lo !== (elo != 0) || valid_hi !== (ehi != 0)) begin
      errors++;
      $display("FAIL %s: lo=%b/%b hi=%b/%b expected lo=%b/%b hi=%b/%b",
               tag, grant_lo, valid_lo, grant_hi, valid_hi, elo, elo != 0, ehi, ehi != 0);
    end
    model_advance(elo, ehi);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    for (int t = 0; t < 8; t++) begin
      m_mul[t] = 0;
      m_fp[t] = 0;
    end
    m_busy = 1'b0; m_owner = 0; m_plo = 0; m_phi = 0;
    rst = 1'b0;
  endtask

  function automatic logic [15:0] all_op(logic [1:0] c);
    return {8{c}};
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    do_reset();
    thr_ready = 8'h00;
    step("R10 R2 idle after reset");
    thr_ready = 8'hFF; thr_op = all_op(2'd0);
    step("R10 pointers at thread 0 and 4");
    repeat (5) step("R3 rotation");
    thr_ready = 8'h0A;
    repeat (3) step("R3 sparse ready");

    do_reset();
    thr_ready = 8'h06; thr_op = all_op(2'd1);
    repeat (12) step("R5 R4 multiply block");

    do_reset();
    thr_op = all_op(2'd0);
    thr_op[1:0] = 2'd2; thr_op[11:10] = 2'd2;
    thr_ready = 8'h21;
    step("R7 low group divide wins");
    thr_ready = 8'h61;
    repeat (4) step("R6 divider busy");
    div_done = 1'b1;
    step("R6 done pulse");
    div_done = 1'b0;
    repeat (3) step("R6 divider released");

    do_reset();
    thr_op = all_op(2'd2);
    thr_ready = 8'h00; div_done = 1'b1;
    step("R9 idle done pulse");
    div_done = 1'b0;
    thr_ready = 8'h02;
    step("R9 divide issue");
    thr_ready = 8'h06;
    repeat (3) step("R9 divide still blocks");

    do_reset();
    thr_op = all_op(2'd3);
    thr_fp_dep = 8'h08;
    thr_ready = 8'h88;
    repeat (14) step("R8 dependent fp gap");

    do_reset();
    for (int n = 0; n < 4000; n++) begin
      thr_ready  = 8'($urandom);
      thr_op     = 16'($urandom);
      thr_fp_dep = 8'($urandom);
      div_done   = ($urandom % 8) == 0;
      step("R1 random traffic");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule